// File: doc/BRIEF.md
# Flash Block-Erase Command Controller

This block is the command front end and status register of a block-erasable flash device, limited to erasing. A bus write strobe carries an 8-bit command byte, and the block-select field of the bus address travels with it. From these the controller decodes a two-step erase start, suspension and resumption of a running erase, a choice of read source, and the clearing of error flags. It also checks that the programming voltage is valid and that the protected boot block is unlocked before any erase begins.

Reads are combinational. The output byte is either the array data supplied by the storage, or the status byte. Suspended reads of the block being erased give all ones. A separate erase engine does the timed work. The controller raises a start pulse together with the block index, holds a run request while the erase should advance, and drops that request to ask for a pause. The engine answers with a paused acknowledge and signals the end of the erase with a one-cycle done pulse.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Writing 20h and then D0h starts an erase. The block field presented with D0h is captured on `ers_blk`, `ers_start` pulses for one cycle, `ers_req` rises, and status reads show bit 7 (ready) as 0.
- R2: If the write after 20h is any byte other than D0h, no erase starts, status bits 4 and 5 are set, and reads return the status byte.
- R3: If the programming voltage is invalid when D0h is written, no erase starts and status bits 3 and 5 are set. If the voltage drops while an erase runs, bit 3 alone is set, and the erase still runs to its end.
- R4: While an erase runs, every command except B0h has no effect, and every read returns the status byte.
- R5: B0h during an erase drops `ers_req`. Once the engine acknowledges the pause, status bits 7 and 6 read 1.
- R6: While suspended, FFh selects array reads and 70h selects status reads. In array mode, a read of the suspended block returns FFh and a read of any other block returns `arr_data`.
- R7: If D0h arrives after B0h but before the pause is acknowledged, `ers_req` returns high at once and bit 6 is never set.
- R8: When the engine's done pulse arrives, bit 7 reads 1, and reads keep returning status until a read-mode command is written.
- R9: An erase aimed at the boot block starts only if `rp_hv` or `wp_hi` is high. Otherwise bit 5 is set and no erase starts.
- R10: Bits 3, 4 and 5 stay set until 50h is written. Other commands and erase completion do not clear them. While bit 3 is set, a confirm does not start an erase and sets bit 5.
- R11: The status byte is laid out as bit 7 ready, bit 6 suspended, bit 5 erase error, bit 4 sequence error, bit 3 voltage error, with bits 2..0 always 0. After reset, reads return array data and the status byte is 80h.
- R12: D0h while suspended resumes the erase. `ers_req` rises, and status reads show bits 7 and 6 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle command write strobe |
| wr_data | input | 8 | Command byte |
| blk_addr | input | BLK_W | Block-select field of the bus address |
| vpp_ok | input | 1 | Programming voltage within range |
| rp_hv | input | 1 | Reset pin held at high voltage (boot unlock) |
| wp_hi | input | 1 | Write-protect pin high (boot unlock) |
| arr_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data: array byte, status byte or erased-block filler |
| ers_start | output | 1 | One-cycle pulse that starts the engine |
| ers_blk | output | BLK_W | Block index for the engine |
| ers_req | output | 1 | Run request: high means the erase advances |
| ers_ack | input | 1 | Engine has paused after the request fell |
| ers_done | input | 1 | One-cycle pulse at erase completion |

## Verification
The assertions rely on the engine behaving as described. `ers_ack` is raised only while the run request is low and an erase is open. `ers_done` pulses only for an erase the controller started. Each write strobe lasts a single cycle. The bench engine model keeps to these rules: it counts only while the request is high, acknowledges a pause a fixed number of cycles after the request falls, and clears that acknowledge as soon as the request returns. Command writes are driven as isolated single-cycle strobes spaced at least one cycle apart.

// File: rtl/flec_pkg.sv
package flec_pkg;

    localparam logic [7:0] CMD_ERS_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
    localparam logic [7:0] CMD_RD_STAT   = 8'h70;
    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RUN,
        ST_SUSP_PEND,
        ST_SUSP
    } ctl_state_t;

    typedef enum logic {
        RM_ARRAY,
        RM_STATUS
    } rd_mode_t;

    // sticky-flag update requests from the sequencer
    typedef struct packed {
        logic set_vpp;
        logic set_seq;
        logic set_ers;
        logic clr;
    } err_upd_t;

    typedef struct packed {
        logic ready;
        logic susp;
        logic ers_err;
        logic seq_err;
        logic vpp_err;
    } stat_t;

    function automatic logic [7:0] pack_status(stat_t s);
        return {s.ready, s.susp, s.ers_err, s.seq_err, s.vpp_err, 3'b000};
    endfunction

    function automatic logic busy_state(ctl_state_t s);
        return (s == ST_RUN) || (s == ST_SUSP_PEND);
    endfunction

endpackage

// File: rtl/flec_status_reg.sv
module flec_status_reg
    import flec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_upd_t   upd,
    input  ctl_state_t state,
    output logic [7:0] stat_byte,
    output logic       vpp_err
);
    logic  vpp_q, seq_q, ers_q;
    stat_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            vpp_q <= 1'b0;
            seq_q <= 1'b0;
            ers_q <= 1'b0;
        end else if (upd.clr) begin
            vpp_q <= 1'b0;
            seq_q <= 1'b0;
            ers_q <= 1'b0;
        end else begin
            vpp_q <= vpp_q | upd.set_vpp;
            seq_q <= seq_q | upd.set_seq;
            ers_q <= ers_q | upd.set_ers;
        end
    end

    always_comb begin
        st.ready   = !busy_state(state);
        st.susp    = (state == ST_SUSP);
        st.ers_err = ers_q;
        st.seq_err = seq_q;
        st.vpp_err = vpp_q;
    end

    assign stat_byte = pack_status(st);
    assign vpp_err   = vpp_q;

    // R10: error flags only fall on an explicit clear
    p_sticky_vpp_r10: assert property (@(posedge clk) disable iff (rst)
        (vpp_q && !upd.clr) |=> vpp_q);
    p_sticky_ers_r10: assert property (@(posedge clk) disable iff (rst)
        (ers_q && !upd.clr) |=> ers_q);

endmodule

// File: rtl/flec_cmd_fsm.sv
module flec_cmd_fsm
    import flec_pkg::*;
#(
    parameter int BLK_W    = 3,
    parameter int BOOT_BLK = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [BLK_W-1:0] blk_addr,
    input  logic             vpp_ok,
    input  logic             rp_hv,
    input  logic             wp_hi,
    input  logic             vpp_err,
    input  logic             ers_ack,
    input  logic             ers_done,
    output ctl_state_t       state,
    output rd_mode_t         rd_mode,
    output err_upd_t         upd,
    output logic             ers_req,
    output logic             ers_start,
    output logic [BLK_W-1:0] ers_blk
);
    localparam logic [BLK_W-1:0] BOOT_IDX = BLK_W'(BOOT_BLK);

    ctl_state_t nxt_state;
    rd_mode_t   nxt_mode;
    logic       start_n;
    logic       boot_locked;

    assign boot_locked = (blk_addr == BOOT_IDX) && !(rp_hv || wp_hi);

    always_comb begin
        nxt_state = state;
        nxt_mode  = rd_mode;
        upd       = '0;
        start_n   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    case (wr_data)
                        CMD_ERS_SETUP: begin
                            nxt_state = ST_SETUP;
                            nxt_mode  = RM_STATUS;
                        end
                        CMD_RD_STAT:  nxt_mode = RM_STATUS;
                        CMD_RD_ARRAY: nxt_mode = RM_ARRAY;
                        CMD_CLR_STAT: upd.clr  = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_SETUP: begin
                if (wr_en) begin
                    nxt_state = ST_IDLE;
                    nxt_mode  = RM_STATUS;
                    if (wr_data != CMD_CONFIRM) begin
                        upd.set_seq = 1'b1;
                        upd.set_ers = 1'b1;
                    end else if (vpp_err || !vpp_ok) begin
                        upd.set_ers = 1'b1;
                        upd.set_vpp = !vpp_ok;
                    end else if (boot_locked) begin
                        upd.set_ers = 1'b1;
                    end else begin
                        nxt_state = ST_RUN;
                        start_n   = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                upd.set_vpp = !vpp_ok;
                if (ers_done) begin
                    nxt_state = ST_IDLE;
                    nxt_mode  = RM_STATUS;
                end else if (wr_en && wr_data == CMD_SUSPEND) begin
                    nxt_state = ST_SUSP_PEND;
                end
            end
            ST_SUSP_PEND: begin
                upd.set_vpp = !vpp_ok;
                if (ers_done) begin
                    nxt_state = ST_IDLE;
                    nxt_mode  = RM_STATUS;
                end else if (wr_en && wr_data == CMD_CONFIRM) begin
                    nxt_state = ST_RUN;
                end else if (ers_ack) begin
                    nxt_state = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (wr_en) begin
                    case (wr_data)
                        CMD_RD_ARRAY: nxt_mode = RM_ARRAY;
                        CMD_RD_STAT:  nxt_mode = RM_STATUS;
                        CMD_CONFIRM: begin
                            nxt_state = ST_RUN;
                            nxt_mode  = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rd_mode   <= RM_ARRAY;
            ers_start <= 1'b0;
            ers_blk   <= '0;
        end else begin
            state     <= nxt_state;
            rd_mode   <= nxt_mode;
            ers_start <= start_n;
            if (start_n) ers_blk <= blk_addr;
        end
    end

    assign ers_req = (state == ST_RUN);

    // R5: suspension is entered only after the engine acknowledged the pause
    p_susp_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSP && $past(state) == ST_SUSP_PEND) |-> $past(ers_ack));
    // R9: a boot-block erase start needs an unlock pin in the confirm cycle
    p_boot_guard_r9: assert property (@(posedge clk) disable iff (rst)
        (ers_start && ers_blk == BOOT_IDX) |-> $past(rp_hv || wp_hi));

endmodule

// File: rtl/flec_rd_mux.sv
module flec_rd_mux
    import flec_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  ctl_state_t       state,
    input  rd_mode_t         rd_mode,
    input  logic [BLK_W-1:0] blk_addr,
    input  logic [BLK_W-1:0] ers_blk,
    input  logic [7:0]       arr_data,
    input  logic [7:0]       stat_byte,
    output logic [7:0]       rd_data
);
    logic sel_status;
    logic hide_blk;

    assign sel_status = (rd_mode == RM_STATUS) || (state == ST_SETUP) || busy_state(state);
    assign hide_blk   = (state == ST_SUSP) && (blk_addr == ers_blk);

    always_comb begin
        if (sel_status)    rd_data = stat_byte;
        else if (hide_blk) rd_data = 8'hFF;
        else               rd_data = arr_data;
    end

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flec_pkg::*;
#(
    parameter int BLK_W    = 3,
    parameter int BOOT_BLK = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [BLK_W-1:0] blk_addr,
    input  logic             vpp_ok,
    input  logic             rp_hv,
    input  logic             wp_hi,
    input  logic [7:0]       arr_data,
    output logic [7:0]       rd_data,
    output logic             ers_start,
    output logic [BLK_W-1:0] ers_blk,
    output logic             ers_req,
    input  logic             ers_ack,
    input  logic             ers_done
);
    ctl_state_t state;
    rd_mode_t   rd_mode;
    err_upd_t   upd;
    logic [7:0] stat_byte;
    logic       vpp_err;

    flec_cmd_fsm #(.BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .blk_addr  (blk_addr),
        .vpp_ok    (vpp_ok),
        .rp_hv     (rp_hv),
        .wp_hi     (wp_hi),
        .vpp_err   (vpp_err),
        .ers_ack   (ers_ack),
        .ers_done  (ers_done),
        .state     (state),
        .rd_mode   (rd_mode),
        .upd       (upd),
        .ers_req   (ers_req),
        .ers_start (ers_start),
        .ers_blk   (ers_blk)
    );

    flec_status_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .state     (state),
        .stat_byte (stat_byte),
        .vpp_err   (vpp_err)
    );

    flec_rd_mux #(.BLK_W(BLK_W)) u_mux (
        .state     (state),
        .rd_mode   (rd_mode),
        .blk_addr  (blk_addr),
        .ers_blk   (ers_blk),
        .arr_data  (arr_data),
        .stat_byte (stat_byte),
        .rd_data   (rd_data)
    );

    // R1: a start pulse comes with the run request
    p_start_req_r1: assert property (@(posedge clk) disable iff (rst)
        ers_start |-> ers_req);
    // R4: while running, reads show a busy status byte with zero low bits
    p_busy_status_r4: assert property (@(posedge clk) disable iff (rst)
        ers_req |-> (rd_data[7] == 1'b0 && rd_data[2:0] == 3'b000));
    // R10: no erase starts while the voltage flag was set at confirm
    p_no_start_vpp_r10: assert property (@(posedge clk) disable iff (rst)
        ers_start |-> ($past(!vpp_err) && $past(vpp_ok)));

endmodule

// File: tb/flash_erase_ctrl_tb.sv
module flash_erase_ctrl_tb;
    localparam int BLK_W     = 3;
    localparam int BOOT      = 7;
    localparam int ERS_LEN   = 40;
    localparam int PAUSE_LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic [BLK_W-1:0] blk_addr = '0;
    logic             vpp_ok = 1'b1;
    logic             rp_hv = 1'b0;
    logic             wp_hi = 1'b0;
    logic [7:0]       arr_data = 8'h00;
    logic [7:0]       rd_data;
    logic             ers_start;
    logic [BLK_W-1:0] ers_blk;
    logic             ers_req;
    logic             ers_ack;
    logic             ers_done;

    flash_erase_ctrl #(.BLK_W(BLK_W), .BOOT_BLK(BOOT)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .blk_addr(blk_addr), .vpp_ok(vpp_ok), .rp_hv(rp_hv), .wp_hi(wp_hi),
        .arr_data(arr_data), .rd_data(rd_data), .ers_start(ers_start),
        .ers_blk(ers_blk), .ers_req(ers_req), .ers_ack(ers_ack),
        .ers_done(ers_done)
    );

    // erase engine model
    logic running;
    int   cnt, lowcnt, starts;
    logic done_q;
    always @(posedge clk) begin
        if (rst) begin
            running <= 1'b0; cnt <= 0; lowcnt <= 0; starts <= 0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ers_start) begin
                running <= 1'b1; cnt <= 0; lowcnt <= 0; starts <= starts + 1;
            end else if (running) begin
                if (ers_req) begin
                    lowcnt <= 0;
                    if (cnt == ERS_LEN - 1) begin
                        done_q <= 1'b1; running <= 1'b0;
                    end else cnt <= cnt + 1;
                end else if (lowcnt < PAUSE_LAT) lowcnt <= lowcnt + 1;
            end
        end
    end
    assign ers_ack  = running && !ers_req && (lowcnt == PAUSE_LAT);
    assign ers_done = done_q;

    // scoreboard
    typedef struct {
        int    kind;   // 0 rd_data, 1 ers_req, 2 ers_blk, 3 start count
        int    exp;
        string tag;
    } item_t;
    item_t q[$];
    int vectors = 0;
    int miscompares = 0;
    int exp_starts = 0;
    bit finished = 0;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                int act;
                it = q.pop_front();
                case (it.kind)
                    0: act = int'(rd_data);
                    1: act = int'(ers_req);
                    2: act = int'(ers_blk);
                    default: act = starts;
                endcase
                vectors++;
                if (act != it.exp) begin
                    miscompares++;
                    $display("FAIL %s kind %0d: actual %0h expected %0h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(int k, int e, string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(logic [7:0] d, logic [BLK_W-1:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; blk_addr = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // read check: block field, array byte offered, expected read byte, expected req
    task automatic look(logic [BLK_W-1:0] b, logic [7:0] arr, logic [7:0] e, int req, string tag);
        @(negedge clk);
        blk_addr = b; arr_data = arr;
        push(0, int'(e), tag);
        if (req >= 0) push(1, req, tag);
        push(3, exp_starts, tag);
        @(negedge clk);
    endtask

    task automatic erase(logic [BLK_W-1:0] b);
        wr(8'h20, '0);
        wr(8'hD0, b);
    endtask

    task automatic wait_ready(string tag);
        bit ok;
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rd_data[7] && !ers_req) begin ok = 1; break; end
        end
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual not ready expected ready", tag);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state reads array, status 80h
        look(3'd1, 8'h3C, 8'h3C, 0, "R11 reset array");
        wr(8'h70, '0);
        look(3'd1, 8'h3C, 8'h80, 0, "R11 reset status");

        // R2: bad second byte
        erase_bad();
        look(3'd0, 8'h11, 8'hB0, 0, "R2 seq error");
        // R10: sticky across other commands
        wr(8'hFF, '0);
        wr(8'h70, '0);
        look(3'd0, 8'h11, 8'hB0, 0, "R10 sticky");
        wr(8'h50, '0);
        look(3'd0, 8'h11, 8'h80, 0, "R10 clear");

        // R3: voltage invalid at confirm
        vpp_ok = 1'b0;
        erase(3'd2);
        vpp_ok = 1'b1;
        look(3'd0, 8'h11, 8'hA8, 0, "R3 vpp at confirm");
        // R10: with SR3 set no erase starts
        erase(3'd2);
        look(3'd0, 8'h11, 8'hA8, 0, "R10 blocked by vpp flag");
        wr(8'h50, '0);
        // combined 0xB8
        erase_bad();
        vpp_ok = 1'b0;
        erase(3'd2);
        vpp_ok = 1'b1;
        look(3'd0, 8'h11, 8'hB8, 0, "R10 combined flags");
        wr(8'h50, '0);

        // R9: boot block locked
        erase(3'(BOOT));
        look(3'd0, 8'h11, 8'hA0, 0, "R9 boot locked");
        wr(8'h50, '0);
        wp_hi = 1'b1;
        erase(3'(BOOT));
        exp_starts++;
        wp_hi = 1'b0;
        @(negedge clk); push(2, BOOT, "R9 boot blk"); @(negedge clk);
        look(3'd0, 8'h11, 8'h00, 1, "R9 boot wp unlock");
        wait_ready("R8 boot done");
        rp_hv = 1'b1;
        erase(3'(BOOT));
        exp_starts++;
        rp_hv = 1'b0;
        look(3'd0, 8'h11, 8'h00, 1, "R9 boot rp unlock");
        wait_ready("R8 boot done 2");

        // R1 / R4: normal erase, ignored commands
        erase(3'd3);
        exp_starts++;
        @(negedge clk); push(2, 3, "R1 blk"); @(negedge clk);
        look(3'd3, 8'h11, 8'h00, 1, "R1 running");
        wr(8'h70, '0);
        wr(8'hFF, '0);
        wr(8'h50, '0);
        wr(8'h20, '0);
        look(3'd5, 8'h22, 8'h00, 1, "R4 ignored");
        wait_ready("R8 done");
        look(3'd5, 8'h22, 8'h80, 0, "R8 status after done");
        @(negedge clk);
        look(3'd5, 8'h22, 8'h80, 0, "R8 status persists");
        wr(8'hFF, '0);
        look(3'd5, 8'h22, 8'h22, 0, "R8 array after FF");

        // R5 / R6 / R12: suspend and resume
        erase(3'd2);
        exp_starts++;
        wr(8'hB0, '0);
        look(3'd0, 8'h11, 8'h00, 0, "R5 req drop");
        repeat (8) @(negedge clk);
        look(3'd0, 8'h11, 8'hC0, 0, "R5 suspended");
        wr(8'hFF, '0);
        look(3'd2, 8'h44, 8'hFF, 0, "R6 erased block hidden");
        look(3'd6, 8'h44, 8'h44, 0, "R6 other block array");
        wr(8'h70, '0);
        look(3'd6, 8'h44, 8'hC0, 0, "R6 status in suspend");
        wr(8'h20, '0);
        look(3'd6, 8'h44, 8'hC0, 0, "R6 other cmd ignored");
        wr(8'hD0, '0);
        look(3'd6, 8'h44, 8'h00, 1, "R12 resume");
        wait_ready("R12 done");
        look(3'd6, 8'h44, 8'h80, 0, "R12 final status");

        // R7: resume before suspension reached
        erase(3'd1);
        exp_starts++;
        wr(8'hB0, '0);
        wr(8'hD0, '0);
        look(3'd1, 8'h11, 8'h00, 1, "R7 early resume");
        repeat (6) @(negedge clk);
        look(3'd1, 8'h11, 8'h00, 1, "R7 no suspend");
        wait_ready("R7 done");

        // R3: voltage loss mid-erase
        erase(3'd4);
        exp_starts++;
        @(negedge clk); vpp_ok = 1'b0;
        repeat (2) @(negedge clk);
        vpp_ok = 1'b1;
        look(3'd4, 8'h11, 8'h08, 1, "R3 vpp during erase");
        wait_ready("R3 done");
        look(3'd4, 8'h11, 8'h88, 0, "R3 vpp-only error");
        wr(8'h50, '0);
        look(3'd4, 8'h11, 8'h80, 0, "R10 cleared");

        repeat (3) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

    task automatic erase_bad;
        wr(8'h20, '0);
        wr(8'h55, '0);
    endtask

endmodule